// File: doc/BRIEF.md
# Instruction Cache Index Parity Scrubber

The scrubber checks one instruction-cache index across all of its ways. A scan begins with a start pulse carrying the 13-bit index and a flag that says whether line data is checked as well as tags. The block then takes words from a valid/ready stream. Each way sends one tag beat first: the high tag word arrives on the 32-bit lane and the low tag word on the 64-bit lane. When data checking is enabled, four data beats follow the tag beat. In a data beat the side word arrives on the 32-bit lane, instruction A on bits 63..32 of the wide lane and instruction B on bits 31..0.

For each tag beat the block reports the way number, whether the line is valid, whether this way's tag is bad, and a rebuilt virtual address. From way 0 it also takes the replacement ordering. A tag-parity flag and a data-parity flag collect errors across the whole index. Both flags are shown with a one-cycle done pulse after the last beat, and both are cleared when the next scan starts. The bank and set numbers come from the index.

The sequence is held by a four-state machine. IDLE waits for start. TAG takes the tag beat of the current way. DATA takes that way's four data beats. DONE lasts one cycle and pulses done. The transitions are: IDLE to TAG on start. TAG to DATA on a handshake when data checking is on. TAG to TAG on the next way, or TAG to DONE after the last way, when data checking is off. DATA to TAG after the fourth beat of a way that is not the last. DATA to DONE after the fourth beat of the last way. DONE to IDLE always.

Top module: `icache_idx_scrub`

## Requirements
- R1: High-tag bit 29 is the line-valid bit and high-tag bit 27 is its even-parity copy. When the two bits differ, the way reports a tag error and the tag-parity flag is set, whether or not the line is valid.
- R2: For a valid line, the XOR of low-tag bits 23..12 and 9..0 must equal low-tag bit 10; a mismatch is a tag error. For an invalid line this check has no effect.
- R3: For a valid line, the XOR of low-tag bits 63..24 must equal low-tag bit 11; a mismatch is a tag error. For an invalid line this check has no effect.
- R4: In a data beat, the XOR of side-word bits 15..8 (the predecode byte) must equal side-word bit 16; a mismatch sets the data-parity flag.
- R5: Side-word bits 7..4 hold the even parity of the four bytes of instruction A (wide-lane bits 63..32), and bits 3..0 hold the parity of instruction B (bits 31..0). Nibble bit 3 covers the most significant byte. Any mismatch in any of the four data beats of any way sets the data-parity flag.
- R6: Each way takes one tag beat, then four data beats when data checking is enabled, for four ways in all. Ready is high only during TAG and DATA. A way report pulses in the cycle after its tag handshake. Done pulses in the cycle after the final handshake, and busy falls one cycle after that.
- R7: The replacement ordering output takes high-tag bits 21..14 of way 0, one cycle after that tag beat. Its two-bit pairs name ways, and the least significant pair is the least recently used way. The output does not change on the tag beats of other ways.
- R8: The reported address keeps low-tag bits 63..62 and 43..13, clears every other bit, and ORs in the index. When low-tag bit 31 is set and bits 63..62 are both one, address bits 61..44 are forced to one.
- R9: Both flags hold their value across all ways of a scan. A start accepted while idle clears them. A start raised while busy or in DONE is ignored.
- R10: The bank output is index bits 6..5 and the set output is index bits 12..7. Both take the index that start accepts, from the cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a scan when idle |
| index_i | input | 13 | Cache index for the scan |
| data_chk_en_i | input | 1 | Enables the data beats |
| beat_valid_i | input | 1 | Stream word valid |
| beat_ready_o | output | 1 | Stream word ready |
| beat_hi_i | input | 32 | High tag word or side word |
| beat_lo_i | input | 64 | Low tag word or instruction pair |
| way_rpt_valid_o | output | 1 | Way report pulse |
| way_rpt_num_o | output | 2 | Way number of the report |
| way_line_valid_o | output | 1 | Line valid bit of the reported way |
| way_tag_err_o | output | 1 | Tag error in the reported way |
| way_va_o | output | 64 | Rebuilt virtual address |
| lru_order_o | output | 8 | Four two-bit way numbers, LRU in the low pair |
| bank_o | output | 2 | Bank number |
| set_o | output | 6 | Set number |
| busy_o | output | 1 | Scan in progress or done cycle |
| done_o | output | 1 | Scan complete pulse |
| tag_err_o | output | 1 | Accumulated tag-parity flag |
| data_err_o | output | 1 | Accumulated data-parity flag |

## Verification
Every result comes from one register stage. A way report, an ordering update and a flag change appear one cycle after the handshake that caused them. Done appears one cycle after the final handshake, and bank and set appear one cycle after start. The bench drives each beat on a falling edge, lets the handshake take place on the next rising edge, and checks the outputs on the falling edge after that. Each check therefore samples in the exact cycle its result is due, and the done check samples in the cycle straight after the final handshake.

// File: rtl/icps_pkg.sv
package icps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } scan_st_e;

    localparam int HI_W     = 32;
    localparam int LO_W     = 64;
    localparam int INSN_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int INSN_BYTES = INSN_W / BYTE_W;
endpackage

// File: rtl/icps_tag_chk.sv
module icps_tag_chk #(
    parameter int IDX_W      = 13,
    parameter int VLD_BIT    = 29,
    parameter int VLD_PAR    = 27,
    parameter int P0_BIT     = 10,
    parameter int P1_BIT     = 11,
    parameter int P0_TOP     = 23,
    parameter int P1_LOW     = 24,
    parameter int VA_MID_LO  = 13,
    parameter int VA_MID_HI  = 43,
    parameter int REGION_LO  = 62,
    parameter int SEXT_BIT   = 31
) (
    input  logic [icps_pkg::HI_W-1:0] hi_i,
    input  logic [icps_pkg::LO_W-1:0] lo_i,
    input  logic [IDX_W-1:0]          idx_i,
    output logic                      line_valid_o,
    output logic                      tag_err_o,
    output logic [icps_pkg::LO_W-1:0] va_o
);
    localparam int LO_W = icps_pkg::LO_W;

    logic vld_err;
    logic p0_calc;
    logic p1_calc;
    logic [LO_W-1:0] keep_mask;
    logic [LO_W-1:0] p0_mask;
    logic region_top;

    always_comb begin
        p0_mask = '0;
        for (int i = 0; i <= P0_TOP; i++) begin
            if (i != P0_BIT && i != P1_BIT) p0_mask[i] = 1'b1;
        end
        keep_mask = '0;
        for (int i = 0; i < LO_W; i++) begin
            if ((i >= REGION_LO) || (i >= VA_MID_LO && i <= VA_MID_HI))
                keep_mask[i] = 1'b1;
        end
    end

    assign line_valid_o = hi_i[VLD_BIT];
    assign vld_err      = hi_i[VLD_BIT] ^ hi_i[VLD_PAR];
    assign p0_calc      = ^(lo_i & p0_mask);
    assign p1_calc      = ^lo_i[LO_W-1:P1_LOW];

    assign tag_err_o = vld_err
                     | (line_valid_o & (p0_calc ^ lo_i[P0_BIT]))
                     | (line_valid_o & (p1_calc ^ lo_i[P1_BIT]));

    assign region_top = lo_i[SEXT_BIT] & (&lo_i[LO_W-1:REGION_LO]);

    always_comb begin
        va_o = (lo_i & keep_mask) | {{(LO_W-IDX_W){1'b0}}, idx_i};
        if (region_top) begin
            va_o[REGION_LO-1:VA_MID_HI+1] = '1;
        end
    end
endmodule

// File: rtl/icps_data_chk.sv
module icps_data_chk #(
    parameter int PRE_LO  = 8,
    parameter int PRE_PAR = 16,
    parameter int A_NIB   = 4,
    parameter int B_NIB   = 0
) (
    input  logic [icps_pkg::HI_W-1:0] side_i,
    input  logic [icps_pkg::LO_W-1:0] pair_i,
    output logic                      beat_err_o
);
    import icps_pkg::*;

    logic [INSN_W-1:0]     insn_a;
    logic [INSN_W-1:0]     insn_b;
    logic [INSN_BYTES-1:0] par_a;
    logic [INSN_BYTES-1:0] par_b;
    logic                  pre_err;

    assign insn_a = pair_i[LO_W-1:INSN_W];
    assign insn_b = pair_i[INSN_W-1:0];

    genvar g;
    generate
        for (g = 0; g < INSN_BYTES; g++) begin : g_byte
            assign par_a[g] = ^insn_a[g*BYTE_W +: BYTE_W];
            assign par_b[g] = ^insn_b[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    assign pre_err = (^side_i[PRE_LO +: BYTE_W]) ^ side_i[PRE_PAR];

    assign beat_err_o = pre_err
                      | (par_a != side_i[A_NIB +: INSN_BYTES])
                      | (par_b != side_i[B_NIB +: INSN_BYTES]);
endmodule

// File: rtl/icache_idx_scrub.sv
module icache_idx_scrub #(
    parameter int NUM_WAYS  = 4,
    parameter int NUM_BEATS = 4,
    parameter int IDX_W     = 13,
    parameter int BANK_LSB  = 5,
    parameter int BANK_W    = 2,
    parameter int SET_W     = 6,
    parameter int LRU_LSB   = 14,
    parameter int WAY_W     = $clog2(NUM_WAYS),
    parameter int LRU_W     = NUM_WAYS * WAY_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [IDX_W-1:0]    index_i,
    input  logic                data_chk_en_i,
    input  logic                beat_valid_i,
    output logic                beat_ready_o,
    input  logic [31:0]         beat_hi_i,
    input  logic [63:0]         beat_lo_i,
    output logic                way_rpt_valid_o,
    output logic [WAY_W-1:0]    way_rpt_num_o,
    output logic                way_line_valid_o,
    output logic                way_tag_err_o,
    output logic [63:0]         way_va_o,
    output logic [LRU_W-1:0]    lru_order_o,
    output logic [BANK_W-1:0]   bank_o,
    output logic [SET_W-1:0]    set_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                tag_err_o,
    output logic                data_err_o
);
    import icps_pkg::*;

    localparam int BEAT_W = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1;
    localparam int SET_LSB = BANK_LSB + BANK_W;
    localparam logic [WAY_W-1:0]  LAST_WAY  = WAY_W'(NUM_WAYS - 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NUM_BEATS - 1);

    scan_st_e state_q, state_d;
    logic [WAY_W-1:0]  way_q;
    logic [BEAT_W-1:0] beat_q;
    logic [IDX_W-1:0]  idx_q;
    logic              den_q;
    logic              tag_flag_q;
    logic              data_flag_q;
    logic              hs;
    logic              start_ok;
    logic              t_valid;
    logic              t_err;
    logic [63:0]       t_va;
    logic              d_err;

    icps_tag_chk #(.IDX_W(IDX_W)) tag_chk_i (
        .hi_i         (beat_hi_i),
        .lo_i         (beat_lo_i),
        .idx_i        (idx_q),
        .line_valid_o (t_valid),
        .tag_err_o    (t_err),
        .va_o         (t_va)
    );

    icps_data_chk data_chk_i (
        .side_i     (beat_hi_i),
        .pair_i     (beat_lo_i),
        .beat_err_o (d_err)
    );

    assign hs       = beat_valid_i & beat_ready_o;
    assign start_ok = start_i & (state_q == ST_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_TAG;
            ST_TAG: begin
                if (hs) begin
                    if (den_q)                 state_d = ST_DATA;
                    else if (way_q == LAST_WAY) state_d = ST_DONE;
                    else                       state_d = ST_TAG;
                end
            end
            ST_DATA: begin
                if (hs && beat_q == LAST_BEAT) begin
                    state_d = (way_q == LAST_WAY) ? ST_DONE : ST_TAG;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // State-decoded outputs
    always_comb begin
        beat_ready_o = 1'b0;
        busy_o       = 1'b1;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_TAG:  beat_ready_o = 1'b1;
            ST_DATA: beat_ready_o = 1'b1;
            ST_DONE: done_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    // Scan position counters and latched scan parameters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            way_q  <= '0;
            beat_q <= '0;
            idx_q  <= '0;
            den_q  <= 1'b0;
        end else if (start_ok) begin
            way_q  <= '0;
            beat_q <= '0;
            idx_q  <= index_i;
            den_q  <= data_chk_en_i;
        end else if (hs) begin
            if (state_q == ST_TAG) begin
                beat_q <= '0;
                if (!den_q) way_q <= way_q + 1'b1;
            end else begin
                if (beat_q == LAST_BEAT) begin
                    beat_q <= '0;
                    way_q  <= way_q + 1'b1;
                end else begin
                    beat_q <= beat_q + 1'b1;
                end
            end
        end
    end

    // Per-way report and replacement ordering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            way_rpt_valid_o  <= 1'b0;
            way_rpt_num_o    <= '0;
            way_line_valid_o <= 1'b0;
            way_tag_err_o    <= 1'b0;
            way_va_o         <= '0;
            lru_order_o      <= '0;
        end else begin
            way_rpt_valid_o <= hs & (state_q == ST_TAG);
            if (hs && state_q == ST_TAG) begin
                way_rpt_num_o    <= way_q;
                way_line_valid_o <= t_valid;
                way_tag_err_o    <= t_err;
                way_va_o         <= t_va;
                if (way_q == '0) lru_order_o <= beat_hi_i[LRU_LSB +: LRU_W];
            end
        end
    end

    // Accumulated error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_flag_q  <= 1'b0;
            data_flag_q <= 1'b0;
        end else if (start_ok) begin
            tag_flag_q  <= 1'b0;
            data_flag_q <= 1'b0;
        end else if (hs) begin
            if (state_q == ST_TAG) tag_flag_q  <= tag_flag_q | t_err;
            else                   data_flag_q <= data_flag_q | d_err;
        end
    end

    assign tag_err_o  = tag_flag_q;
    assign data_err_o = data_flag_q;
    assign bank_o     = idx_q[BANK_LSB +: BANK_W];
    assign set_o      = idx_q[SET_LSB +: SET_W];
endmodule

// File: rtl/icps_chk.sv
module icps_chk #(
    parameter int IDX_W = 13,
    parameter int WAY_W = 2,
    parameter int LRU_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             beat_valid_i,
    input logic             beat_ready_o,
    input logic             way_rpt_valid_o,
    input logic [WAY_W-1:0] way_rpt_num_o,
    input logic [LRU_W-1:0] lru_order_o,
    input logic             tag_err_o,
    input logic             data_err_o,
    input logic [63:0]      way_va_o,
    input logic [IDX_W-1:0] idx_q
);
    p_ready_in_scan_r6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ready_o |-> (busy_o && !done_o));

    p_done_then_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    p_rpt_after_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        way_rpt_valid_o |-> $past(beat_valid_i && beat_ready_o));

    p_lru_from_way0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lru_order_o) |-> (way_rpt_valid_o && way_rpt_num_o == '0));

    p_va_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        way_rpt_valid_o |-> (way_va_o[IDX_W-1:0] == idx_q));

    p_clear_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (!tag_err_o && !data_err_o && busy_o));

    p_tag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_err_o && !(start_i && !busy_o)) |=> tag_err_o);

    p_data_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_err_o && !(start_i && !busy_o)) |=> data_err_o);
endmodule

bind icache_idx_scrub icps_chk #(
    .IDX_W (IDX_W),
    .WAY_W (WAY_W),
    .LRU_W (LRU_W)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .beat_valid_i    (beat_valid_i),
    .beat_ready_o    (beat_ready_o),
    .way_rpt_valid_o (way_rpt_valid_o),
    .way_rpt_num_o   (way_rpt_num_o),
    .lru_order_o     (lru_order_o),
    .tag_err_o       (tag_err_o),
    .data_err_o      (data_err_o),
    .way_va_o        (way_va_o),
    .idx_q           (idx_q)
);

// File: tb/icache_idx_scrub_tb_top.sv
`timescale 1ns/1ps
module icache_idx_scrub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [12:0] index_i = '0;
    logic        data_chk_en_i = 1'b0;
    logic        beat_valid_i = 1'b0;
    logic        beat_ready_o;
    logic [31:0] beat_hi_i = '0;
    logic [63:0] beat_lo_i = '0;
    logic        way_rpt_valid_o;
    logic [1:0]  way_rpt_num_o;
    logic        way_line_valid_o;
    logic        way_tag_err_o;
    logic [63:0] way_va_o;
    logic [7:0]  lru_order_o;
    logic [1:0]  bank_o;
    logic [5:0]  set_o;
    logic        busy_o;
    logic        done_o;
    logic        tag_err_o;
    logic        data_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] t_hi [4];
    logic [63:0] t_lo [4];
    logic [31:0] d_side [16];
    logic [63:0] d_pair [16];

    always #4 clk = ~clk;

    icache_idx_scrub dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit m_tag_err(input logic [31:0] hi, input logic [63:0] lo);
        bit e, p0, p1;
        e = hi[29] != hi[27];
        if (hi[29]) begin
            p0 = 0; p1 = 0;
            for (int i = 0; i < 24; i++) if (i != 10 && i != 11) p0 ^= lo[i];
            for (int i = 24; i < 64; i++) p1 ^= lo[i];
            if (p0 != lo[10]) e = 1;
            if (p1 != lo[11]) e = 1;
        end
        return e;
    endfunction

    function automatic logic [63:0] m_va(input logic [63:0] lo, input logic [12:0] idx);
        logic [63:0] v = '0;
        for (int i = 0; i < 64; i++) if (i >= 62 || (i >= 13 && i <= 43)) v[i] = lo[i];
        v = v | {51'd0, idx};
        if (lo[31] && lo[63] && lo[62]) for (int i = 44; i <= 61; i++) v[i] = 1'b1;
        return v;
    endfunction

    function automatic bit byte_par(input logic [31:0] w, input int b);
        bit p = 0;
        for (int i = 0; i < 8; i++) p ^= w[b*8+i];
        return p;
    endfunction

    function automatic bit m_data_err(input logic [31:0] side, input logic [63:0] pair);
        bit e = 0, p = 0;
        for (int i = 8; i < 16; i++) p ^= side[i];
        if (p != side[16]) e = 1;
        for (int b = 0; b < 4; b++) begin
            if (byte_par(pair[63:32], b) != side[4+b]) e = 1;
            if (byte_par(pair[31:0], b) != side[b]) e = 1;
        end
        return e;
    endfunction

    function automatic logic [31:0] fix_hi(input logic [31:0] hi);
        logic [31:0] h = hi;
        h[27] = h[29];
        return h;
    endfunction

    function automatic logic [63:0] fix_lo(input logic [63:0] lo);
        logic [63:0] l = lo;
        bit p0 = 0, p1 = 0;
        for (int i = 0; i < 24; i++) if (i != 10 && i != 11) p0 ^= l[i];
        for (int i = 24; i < 64; i++) p1 ^= l[i];
        l[10] = p0; l[11] = p1;
        return l;
    endfunction

    function automatic logic [31:0] fix_side(input logic [31:0] s, input logic [63:0] pair);
        logic [31:0] r = s;
        bit p = 0;
        for (int i = 8; i < 16; i++) p ^= r[i];
        r[16] = p;
        for (int b = 0; b < 4; b++) begin
            r[4+b] = byte_par(pair[63:32], b);
            r[b]   = byte_par(pair[31:0], b);
        end
        return r;
    endfunction

    task automatic fill_clean(input bit valid);
        for (int w = 0; w < 4; w++) begin
            logic [31:0] h = $urandom;
            h[29] = valid;
            t_hi[w] = fix_hi(h);
            t_lo[w] = fix_lo({$urandom, $urandom});
        end
        for (int k = 0; k < 16; k++) begin
            d_pair[k] = {$urandom, $urandom};
            d_side[k] = fix_side($urandom, d_pair[k]);
        end
    endtask

    task automatic run_scan(input logic [12:0] idx, input bit den, input bit mid_start);
        bit et = 0, ed = 0;
        @(negedge clk);
        start_i = 1; index_i = idx; data_chk_en_i = den;
        @(negedge clk);
        start_i = 0;
        chk(tag_err_o == 0 && data_err_o == 0, "R9 clear on start", {tag_err_o, data_err_o}, 0);
        chk(bank_o == idx[6:5] && set_o == idx[12:7], "R10 bank/set", {bank_o, set_o}, {idx[6:5], idx[12:7]});
        for (int w = 0; w < 4; w++) begin
            if (($urandom & 3) == 0) @(negedge clk);
            chk(beat_ready_o == 1, "R6 ready in scan", beat_ready_o, 1);
            beat_valid_i = 1; beat_hi_i = t_hi[w]; beat_lo_i = t_lo[w];
            if (mid_start && w == 2) begin start_i = 1; index_i = ~idx; end
            @(negedge clk);
            beat_valid_i = 0; start_i = 0;
            et |= m_tag_err(t_hi[w], t_lo[w]);
            chk(way_rpt_valid_o && way_rpt_num_o == w[1:0], "R6 way report", {way_rpt_valid_o, way_rpt_num_o}, {1'b1, w[1:0]});
            chk(way_line_valid_o == t_hi[w][29], "R1 line valid", way_line_valid_o, t_hi[w][29]);
            chk(way_tag_err_o == m_tag_err(t_hi[w], t_lo[w]), "R2/R3 way tag err", way_tag_err_o, m_tag_err(t_hi[w], t_lo[w]));
            chk(way_va_o == m_va(t_lo[w], idx), "R8 va", way_va_o, m_va(t_lo[w], idx));
            chk(lru_order_o == t_hi[0][21:14], "R7 lru", lru_order_o, t_hi[0][21:14]);
            chk(tag_err_o == et, "R1 sticky tag flag", tag_err_o, et);
            if (den) begin
                for (int b = 0; b < 4; b++) begin
                    beat_valid_i = 1; beat_hi_i = d_side[w*4+b]; beat_lo_i = d_pair[w*4+b];
                    @(negedge clk);
                    beat_valid_i = 0;
                    ed |= m_data_err(d_side[w*4+b], d_pair[w*4+b]);
                    chk(way_rpt_valid_o == 0, "R6 no report on data", way_rpt_valid_o, 0);
                    chk(data_err_o == ed, "R4/R5 data flag", data_err_o, ed);
                end
            end
        end
        chk(done_o == 1 && beat_ready_o == 0, "R6 done pulse", {done_o, beat_ready_o}, 2'b10);
        chk(tag_err_o == et, "R9 final tag flag", tag_err_o, et);
        chk(data_err_o == ed, "R9 final data flag", data_err_o, ed);
        @(negedge clk);
        chk(busy_o == 0 && done_o == 0, "R6 idle after done", {busy_o, done_o}, 0);
        chk(tag_err_o == et && data_err_o == ed, "R9 flags hold", {tag_err_o, data_err_o}, {et, ed});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(beat_ready_o == 0 && busy_o == 0 && done_o == 0, "R6 reset state", {beat_ready_o, busy_o, done_o}, 0);
        chk(tag_err_o == 0 && data_err_o == 0 && lru_order_o == 0, "R9 reset flags", {tag_err_o, data_err_o, lru_order_o}, 0);

        // R2 R3: single-bit flips of low tag on valid lines, tag-only scans
        for (int k = 0; k < 64; k++) begin
            fill_clean(1);
            t_lo[k % 4][k] = ~t_lo[k % 4][k];
            run_scan(13'($urandom), 0, 0);
        end
        // R2 R3: same flips on invalid lines have no effect
        for (int k = 0; k < 64; k++) begin
            fill_clean(0);
            t_lo[k % 4][k] = ~t_lo[k % 4][k];
            run_scan(13'($urandom), 0, 0);
        end
        // R1: valid-bit parity mismatch on valid and invalid lines
        for (int k = 0; k < 8; k++) begin
            fill_clean(k[0]);
            t_hi[k / 2][k[1] ? 29 : 27] = ~t_hi[k / 2][k[1] ? 29 : 27];
            run_scan(13'($urandom), 0, 0);
        end
        // R4 R5: single-bit flips of data beats
        for (int k = 0; k < 81; k++) begin
            fill_clean(1);
            if (k < 17) d_side[k % 16][k] = ~d_side[k % 16][k];
            else        d_pair[k % 16][k - 17] = ~d_pair[k % 16][k - 17];
            run_scan(13'($urandom), 1, 0);
        end
        // R8: upper-region address fill
        fill_clean(1);
        for (int w = 0; w < 4; w++) begin
            t_lo[w][63:62] = 2'b11; t_lo[w][31] = w[0];
            t_lo[w] = fix_lo(t_lo[w]);
        end
        run_scan(13'h1fff, 0, 0);
        // R9: start while busy ignored, error flag kept
        fill_clean(1);
        t_hi[1][27] = ~t_hi[1][27];
        run_scan(13'h0a5a, 1, 1);
        fill_clean(1);
        run_scan(13'h1234, 1, 0);
        // Mixed random scans
        for (int n = 0; n < 40; n++) begin
            fill_clean($urandom & 1);
            for (int w = 0; w < 4; w++) if (($urandom & 7) == 0) t_lo[w] ^= 64'd1 << ($urandom % 64);
            for (int b = 0; b < 16; b++) if (($urandom & 15) == 0) d_side[b] ^= 32'd1 << ($urandom % 17);
            run_scan(13'($urandom), $urandom & 1, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule